// File: doc/BRIEF.md
# Character Page Write Sequencer

This block sits behind an already-decoded serial bus slave and turns its framed byte stream into write cycles for a 512-entry character page memory. Each memory entry holds a 9-bit character code and a 4-bit attribute. A transaction opens with a start pulse and closes with a stop pulse. The bytes between them are cut into fixed-size groups, and each complete group produces exactly one memory write.

The addressing mode, sampled at the start pulse, sets the group shape:

- **Sequential:** attribute then code, with the address taken from a preloaded base and stepped by one after every write.
- **Half random:** low address, attribute, code, with the top address bit taken from a half-select input sampled at start.
- **Full random:** low address, high address, attribute, code.

In both random modes the address is never stepped. Bit 8 of the character code travels in the attribute byte.

Top module: `page_wr_seq`

## Requirements
- R1: After reset `we_o` is low and `addr_o`, `code_o` and `attr_o` are zero.
- R2: With `mode_i`=0 (sequential) at start, the groups are [attribute, code]. The first write goes to `base_addr_i` as sampled at start, and each further write in the same transaction goes to the previous address plus one.
- R3: In sequential mode, the address that follows 511 is 0.
- R4: With `mode_i`=1 (half random) at start, the groups are [low address, attribute, code]. The write address is {`half_sel_i` sampled at start, low address byte}, and it is not stepped between writes.
- R5: Changes of `half_sel_i` after the start pulse do not affect the addresses of that transaction.
- R6: With `mode_i`=2 (full random) at start, the groups are [low address, high address, attribute, code]. The write address is {high byte bit 0, low byte}, and high byte bits 7:1 are ignored.
- R7: In the attribute byte, bit 4 becomes `code_o[8]` and bits 3:0 become `attr_o`. Bits 7:5 are ignored. `code_o[7:0]` is the code byte.
- R8: `we_o` is a one-cycle pulse in the cycle after the code byte is accepted, with `addr_o`, `code_o` and `attr_o` valid in that cycle.
- R9: A stop pulse in the middle of a group discards the partial entry, and no write occurs.
- R10: A start pulse always returns the byte position to the first byte of a group, even in the middle of a group.
- R11: Bytes received outside a transaction (before the first start, or after a stop) cause no write.
- R12: The mode is sampled only at start, so later changes of `mode_i` have no effect on the current transaction. With `mode_i`=3 (reserved) at start, no write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start condition pulse from the bus slave |
| stop_i | input | 1 | Stop condition pulse from the bus slave |
| byte_vld_i | input | 1 | Received byte strobe |
| byte_i | input | 8 | Received byte |
| mode_i | input | 2 | Addressing mode: 0 sequential, 1 half random, 2 full random, 3 reserved |
| half_sel_i | input | 1 | Half of the page used in half random mode |
| base_addr_i | input | 9 | Start address for sequential mode |
| we_o | output | 1 | Write strobe to the page memory |
| addr_o | output | 9 | Write address |
| code_o | output | 9 | Character code written |
| attr_o | output | 4 | Attribute written |

## Verification
A table of single-entry transactions covers each mode with attribute bytes that set and clear code bit 8, including attribute bytes whose unused upper bits are set and high address bytes whose unused bits are set. This separates correct field extraction from a plain byte copy. Multi-entry transactions separate the stepping address of sequential mode, including the wrap at 511, from the fixed per-entry addresses of the random modes. Truncated groups, restarts in mid-group, stray bytes outside a transaction and input changes after the start pulse show whether the byte position and the sampled mode and half are handled at the right moments.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
  localparam int BYTE_W      = 8;
  localparam int ADDR_W      = BYTE_W + 1;
  localparam int CODE_W      = BYTE_W + 1;
  localparam int ATTR_W      = 4;
  localparam int CODE_HI_BIT = ATTR_W;
  localparam int POS_W       = 2;

  typedef enum logic [1:0] {
    MODE_SEQ  = 2'd0,
    MODE_HALF = 2'd1,
    MODE_FULL = 2'd2,
    MODE_RSVD = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    ROLE_LO   = 2'd0,
    ROLE_HI   = 2'd1,
    ROLE_ATTR = 2'd2,
    ROLE_CODE = 2'd3
  } role_e;

  function automatic logic [POS_W-1:0] last_pos(mode_e m);
    case (m)
      MODE_SEQ:  return POS_W'(1);
      MODE_HALF: return POS_W'(2);
      MODE_FULL: return POS_W'(3);
      default:   return POS_W'(0);
    endcase
  endfunction

  function automatic role_e role_at(mode_e m, logic [POS_W-1:0] p);
    role_e r;
    r = ROLE_LO;
    case (m)
      MODE_SEQ:  r = (p == 0) ? ROLE_ATTR : ROLE_CODE;
      MODE_HALF: r = (p == 0) ? ROLE_LO : (p == 1) ? ROLE_ATTR : ROLE_CODE;
      MODE_FULL: r = role_e'(p);
      default:   r = ROLE_LO;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/pgwr_frame_ctrl.sv
module pgwr_frame_ctrl
  import pgwr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             byte_vld_i,
  input  logic [1:0]       mode_i,
  input  logic             half_sel_i,
  output logic             accept_o,
  output role_e            role_o,
  output mode_e            mode_o,
  output logic             half_o,
  output logic             active_o
);
  logic             active_q;
  mode_e            mode_q;
  logic             half_q;
  logic [POS_W-1:0] pos_q;

  assign accept_o = byte_vld_i && active_q && !start_i && !stop_i && (mode_q != MODE_RSVD);
  assign role_o   = role_at(mode_q, pos_q);
  assign mode_o   = mode_q;
  assign half_o   = half_q;
  assign active_o = active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      mode_q   <= MODE_SEQ;
      half_q   <= 1'b0;
      pos_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      mode_q   <= mode_e'(mode_i);
      half_q   <= half_sel_i;
      pos_q    <= '0;
    end else if (stop_i) begin
      active_q <= 1'b0;
      pos_q    <= '0;
    end else if (accept_o) begin
      pos_q <= (pos_q == last_pos(mode_q)) ? '0 : pos_q + 1'b1;
    end
  end

  p_pos_bound_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q <= last_pos(mode_q));
  p_start_rewind_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (pos_q == '0) && active_q);
  p_stop_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !start_i) |=> !active_q && (pos_q == '0));
  p_mode_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(mode_q) && $stable(half_q));
endmodule

// File: rtl/pgwr_addr_unit.sv
module pgwr_addr_unit
  import pgwr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic              accept_i,
  input  role_e             role_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  mode_e             mode_i,
  input  logic              half_i,
  output logic [ADDR_W-1:0] wr_addr_o
);
  logic [ADDR_W-1:0] seq_q;
  logic [BYTE_W-1:0] lo_q;
  logic              hi_q;
  logic              code_fire;

  assign code_fire = accept_i && (role_i == ROLE_CODE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_q <= '0;
    end else if (start_i) begin
      seq_q <= base_addr_i;
    end else if (code_fire && (mode_i == MODE_SEQ)) begin
      seq_q <= seq_q + 1'b1;  // wraps at the top of the page
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= 1'b0;
    end else if (accept_i) begin
      if (role_i == ROLE_LO) lo_q <= byte_i;
      if (role_i == ROLE_HI) hi_q <= byte_i[0];
    end
  end

  always_comb begin
    case (mode_i)
      MODE_HALF: wr_addr_o = {half_i, lo_q};
      MODE_FULL: wr_addr_o = {hi_q, lo_q};
      default:   wr_addr_o = seq_q;
    endcase
  end

  p_seq_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_fire && (mode_i == MODE_SEQ)) |=> seq_q == ADDR_W'($past(seq_q) + 1'b1));
  p_rand_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_fire && (mode_i != MODE_SEQ)) |=> $stable(seq_q));
endmodule

// File: rtl/pgwr_entry_out.sv
module pgwr_entry_out
  import pgwr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  role_e             role_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CODE_W-1:0] code_o,
  output logic [ATTR_W-1:0] attr_o
);
  logic              code_hi_q;
  logic [ATTR_W-1:0] attr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_hi_q <= 1'b0;
      attr_q    <= '0;
    end else if (accept_i && (role_i == ROLE_ATTR)) begin
      code_hi_q <= byte_i[CODE_HI_BIT];
      attr_q    <= byte_i[ATTR_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_o   <= 1'b0;
      addr_o <= '0;
      code_o <= '0;
      attr_o <= '0;
    end else begin
      we_o <= 1'b0;
      if (accept_i && (role_i == ROLE_CODE)) begin
        we_o   <= 1'b1;
        addr_o <= wr_addr_i;
        code_o <= {code_hi_q, byte_i};
        attr_o <= attr_q;
      end
    end
  end

  p_strobe_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> !we_o);
  p_out_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_o |=> $stable(addr_o) || we_o);
endmodule

// File: rtl/page_wr_seq.sv
module page_wr_seq
  import pgwr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [1:0]        mode_i,
  input  logic              half_sel_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CODE_W-1:0] code_o,
  output logic [ATTR_W-1:0] attr_o
);
  logic              accept;
  role_e             role;
  mode_e             mode_q;
  logic              half_q;
  logic              active;
  logic [ADDR_W-1:0] wr_addr;

  pgwr_frame_ctrl i_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .stop_i     (stop_i),
    .byte_vld_i (byte_vld_i),
    .mode_i     (mode_i),
    .half_sel_i (half_sel_i),
    .accept_o   (accept),
    .role_o     (role),
    .mode_o     (mode_q),
    .half_o     (half_q),
    .active_o   (active)
  );

  pgwr_addr_unit i_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .base_addr_i (base_addr_i),
    .accept_i    (accept),
    .role_i      (role),
    .byte_i      (byte_i),
    .mode_i      (mode_q),
    .half_i      (half_q),
    .wr_addr_o   (wr_addr)
  );

  pgwr_entry_out i_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .role_i    (role),
    .byte_i    (byte_i),
    .wr_addr_i (wr_addr),
    .we_o      (we_o),
    .addr_o    (addr_o),
    .code_o    (code_o),
    .attr_o    (attr_o)
  );

  p_no_idle_write_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> $past(active));
  p_half_top_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o && (mode_q == MODE_HALF)) |-> (addr_o[ADDR_W-1] == half_q));
  p_rsvd_silent_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_RSVD) |=> !we_o);
endmodule

// File: tb/test_page_wr_seq.sv
`timescale 1ns/1ps
module test_page_wr_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, stop = 1'b0, vld = 1'b0;
  logic [7:0] bt = '0;
  logic [1:0] mode = '0;
  logic       half = 1'b0;
  logic [8:0] base = '0;
  logic       we;
  logic [8:0] addr, code;
  logic [3:0] attr;

  int n_chk = 0, n_fail = 0, wr_cnt = 0;

  always #4 clk = ~clk;
  always @(posedge clk) if (we) wr_cnt++;

  page_wr_seq i_page_wr_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop),
    .byte_vld_i(vld), .byte_i(bt), .mode_i(mode), .half_sel_i(half),
    .base_addr_i(base), .we_o(we), .addr_o(addr), .code_o(code), .attr_o(attr)
  );

  typedef struct packed {
    logic [1:0] md;
    logic       hs;
    logic [8:0] bs;
    logic [7:0] b0, b1, b2, b3;
    logic [8:0] ea;
    logic [8:0] ec;
    logic [3:0] eat;
  } vec_t;

  localparam vec_t VECS [0:7] = '{
    '{2'd0, 1'b0, 9'd5,   8'h1A, 8'h33, 8'h00, 8'h00, 9'd5,    9'h133, 4'hA},
    '{2'd0, 1'b0, 9'd300, 8'hE3, 8'hFF, 8'h00, 8'h00, 9'd300,  9'h0FF, 4'h3},
    '{2'd1, 1'b0, 9'd0,   8'h7F, 8'h15, 8'h41, 8'h00, 9'h07F,  9'h141, 4'h5},
    '{2'd1, 1'b1, 9'd0,   8'h00, 8'h0C, 8'h80, 8'h00, 9'h100,  9'h080, 4'hC},
    '{2'd2, 1'b0, 9'd0,   8'hAB, 8'h01, 8'h19, 8'h5A, 9'h1AB,  9'h15A, 4'h9},
    '{2'd2, 1'b1, 9'd0,   8'h10, 8'hFE, 8'h02, 8'h00, 9'h010,  9'h000, 4'h2},
    '{2'd2, 1'b0, 9'd0,   8'hFF, 8'h03, 8'hF0, 8'h7E, 9'h1FF,  9'h17E, 4'h0},
    '{2'd1, 1'b1, 9'd0,   8'hFF, 8'h1F, 8'h01, 8'h00, 9'h1FF,  9'h101, 4'hF}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic do_stop();
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); vld = 1'b1; bt = b;
    @(negedge clk); vld = 1'b0;
  endtask

  // code byte last; checks the strobe cycle and the cycle after
  task automatic entry_chk(input string tag, input logic [8:0] ea, input logic [8:0] ec, input logic [3:0] eat);
    chk({tag, " we"}, 32'(we), 32'd1);
    chk({tag, " addr"}, 32'(addr), 32'(ea));
    chk({tag, " code"}, 32'(code), 32'(ec));
    chk({tag, " attr"}, 32'(attr), 32'(eat));
    @(negedge clk);
    chk({tag, " we pulse"}, 32'(we), 32'd0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int c0;
    cyc(3);
    // R1 reset state
    chk("R1 we", 32'(we), 32'd0);
    chk("R1 addr", 32'(addr), 32'd0);
    chk("R1 code", 32'(code), 32'd0);
    chk("R1 attr", 32'(attr), 32'd0);
    rst_n = 1'b1;
    // R11 bytes before any start
    send(8'h11); send(8'h22); send(8'h33); send(8'h44); cyc(2);
    chk("R11 pre-start writes", 32'(wr_cnt), 32'd0);

    // vector table, one entry per transaction (R2 R4 R6 R7 R8)
    for (int i = 0; i < 8; i++) begin
      int len;
      logic [7:0] bs [4];
      mode = VECS[i].md; half = VECS[i].hs; base = VECS[i].bs;
      bs[0] = VECS[i].b0; bs[1] = VECS[i].b1; bs[2] = VECS[i].b2; bs[3] = VECS[i].b3;
      len = (VECS[i].md == 2'd0) ? 2 : (VECS[i].md == 2'd1) ? 3 : 4;
      do_start();
      for (int k = 0; k < len; k++) send(bs[k]);
      entry_chk($sformatf("R8 R7 vec%0d", i), VECS[i].ea, VECS[i].ec, VECS[i].eat);
      do_stop();
    end

    // R2 sequential stepping
    mode = 2'd0; base = 9'd10; do_start();
    send(8'h01); send(8'h41); entry_chk("R2 e0", 9'd10, 9'h041, 4'h1);
    send(8'h12); send(8'h42); entry_chk("R2 e1", 9'd11, 9'h142, 4'h2);
    send(8'h03); send(8'h43); entry_chk("R2 e2", 9'd12, 9'h043, 4'h3);
    do_stop();

    // R3 wrap
    base = 9'd511; do_start();
    send(8'h04); send(8'h50); entry_chk("R3 e0", 9'd511, 9'h050, 4'h4);
    send(8'h05); send(8'h51); entry_chk("R3 wrap", 9'd0, 9'h051, 4'h5);
    do_stop();

    // R4 half random, no stepping; R5 half_sel change ignored
    mode = 2'd1; half = 1'b1; do_start(); half = 1'b0;
    send(8'h20); send(8'h06); send(8'h60); entry_chk("R5 e0", 9'h120, 9'h060, 4'h6);
    send(8'h20); send(8'h07); send(8'h61); entry_chk("R4 same addr", 9'h120, 9'h061, 4'h7);
    send(8'h21); send(8'h08); send(8'h62); entry_chk("R5 e2", 9'h121, 9'h062, 4'h8);
    do_stop();

    // R6 full random across halves
    mode = 2'd2; do_start();
    send(8'h05); send(8'h00); send(8'h19); send(8'h70); entry_chk("R6 lo", 9'h005, 9'h170, 4'h9);
    send(8'hF0); send(8'h81); send(8'h0A); send(8'h71); entry_chk("R6 hi", 9'h1F0, 9'h071, 4'hA);
    do_stop();

    // R9 stop mid group
    cyc(2); c0 = wr_cnt;
    do_start(); send(8'h55); send(8'h01); send(8'h1B); do_stop(); cyc(2);
    chk("R9 no write", 32'(wr_cnt), 32'(c0));
    do_start();
    send(8'h33); send(8'h00); send(8'h01); send(8'h44); entry_chk("R9 next", 9'h033, 9'h044, 4'h1);
    do_stop();

    // R10 restart mid group
    mode = 2'd1; half = 1'b0; cyc(2); c0 = wr_cnt;
    do_start(); send(8'h50); send(8'h1C);
    do_start(); send(8'h60); send(8'h02); send(8'h77);
    entry_chk("R10 restart", 9'h060, 9'h077, 4'h2);
    cyc(2);
    chk("R10 one write", 32'(wr_cnt), 32'(c0 + 1));

    // R11 bytes after stop
    mode = 2'd0; do_start(); do_stop(); c0 = wr_cnt;
    send(8'h01); send(8'h02); send(8'h03); send(8'h04); cyc(2);
    chk("R11 post-stop writes", 32'(wr_cnt), 32'(c0));

    // R12 reserved mode
    mode = 2'd3; do_start(); c0 = wr_cnt;
    send(8'h01); send(8'h02); send(8'h03); send(8'h04); cyc(2);
    chk("R12 reserved", 32'(wr_cnt), 32'(c0));
    do_stop();

    // R12 mode change after start ignored
    mode = 2'd0; base = 9'd77; do_start(); mode = 2'd2;
    send(8'h0D); send(8'h88); entry_chk("R12 mode held", 9'd77, 9'h088, 4'hD);
    do_stop();

    summary();
    $finish;
  end
endmodule